// File: doc/BRIEF.md
# Peak Hold Register with Programmable Timeout

This block sits after a decimation filter. It keeps track of the largest and the smallest signed sample seen in the decimated stream. A level display, an automatic gain loop or a clip detector can read the two values at any time. Without a timeout, the values would hold the extremes of the whole run. Software would then have to clear them.

The timeout is built into the block instead. A counter advances once for every sample-rate strobe. When the upper part of the counter equals a programmed wait value, both extreme registers fall back to their idle values. The counter then starts again, and a one-cycle pulse marks the event. With 24 counter bits and a 12-bit wait value at a 20 kHz strobe, one wait step is 4096 strobes, about 205 ms. The largest wait value gives about 14 minutes. A wait value of zero turns the timeout off.

Top module: `peak_hold_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, `max_o` holds the most negative code (18'h20000, -131072), `min_o` holds the most positive code (18'h1FFFF, 131071), and `clear_o` is low.
- R2: A sample with `smp_vld_i` high replaces `max_o` when it is greater than the stored maximum, and replaces `min_o` when it is smaller than the stored minimum. Both comparisons treat the values as two's complement. The new value is visible in the cycle after the sampling edge.
- R3: A sample presented while `smp_vld_i` is low changes neither `max_o` nor `min_o`.
- R4: A 24-bit counter restarts at zero and advances by one at each edge where `tick_i` is high. The wait value W is nonzero and unchanged. Once the counter has reached W*4096, the next edge clears the registers and returns the counter to zero, and any tick on that edge is dropped. With `tick_i` held high, clears therefore recur every W*4096+1 cycles.
- R5: While `wait_i` is zero, no clear takes place.
- R6: At any edge where `wait_i` differs from its value at the previous edge, the counter restarts from zero. This restart takes priority over a pending match, so no clear happens at that edge.
- R7: If a valid sample arrives at a clearing edge, both `max_o` and `min_o` take that sample.
- R8: `clear_o` is high for exactly one cycle, the cycle after each clearing edge, and low at all other times.
- R9: At a clearing edge without a valid sample, `max_o` returns to the most negative code and `min_o` to the most positive code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample-rate strobe that advances the timeout counter |
| smp_vld_i | input | 1 | Qualifies `smp_i` |
| smp_i | input | 18 | Signed decimated sample |
| wait_i | input | 12 | Wait period in steps of 4096 ticks; zero disables the timeout |
| max_o | output | 18 | Largest valid sample since the last clear |
| min_o | output | 18 | Smallest valid sample since the last clear |
| clear_o | output | 1 | One-cycle pulse after a timeout clear |

## Verification
The bench uses the two extreme codes as samples. A design that compared the values as unsigned would take -1 as the maximum, and one with the wrong idle values would never accept the most negative sample. The bench measures the interval between clears in ticks. An off-by-one in the match or in the counter restart shifts every pulse by a cycle. The bench also holds a valid sample across a clear, which exposes a design that lets the clear win and loses the sample. A wait change in mid-count and a zero wait are both driven. These show whether a design keeps counting toward a stale target or fires a clear when the timeout should be off.

// File: rtl/pkh_pkg.sv
package pkh_pkg;

    // Default geometry of the block
    localparam int SMP_W_DEF  = 18;
    localparam int CNT_W_DEF  = 24;
    localparam int WAIT_W_DEF = 12;

    // Which extreme a tracking register follows
    typedef enum logic {
        TRK_MAX = 1'b0,
        TRK_MIN = 1'b1
    } pkh_dir_e;

    // Update command shared by both tracking registers
    typedef struct packed {
        logic clr;   // timeout clear at this edge
        logic vld;   // valid sample at this edge
    } pkh_upd_t;

    // Timer state carried between the timer stages
    typedef struct packed {
        logic restart;  // wait value changed
        logic match;    // counter reached the programmed period
    } pkh_evt_t;

    function automatic pkh_upd_t pkh_make_upd(input logic clr, input logic vld);
        pkh_upd_t u;
        u.clr = clr;
        u.vld = vld;
        return u;
    endfunction

endpackage

// File: rtl/pkh_timeout.sv
module pkh_timeout
    import pkh_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int WAIT_W = WAIT_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic              clr_o,
    output logic              pulse_o
);

    localparam int LOW_W = CNT_W - WAIT_W;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [WAIT_W-1:0] wait_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    pkh_evt_t          evt;

    // Event decode: a changed wait value wins over a match
    always_comb begin
        evt.restart = (wait_i != wait_q);
        evt.match   = !evt.restart && (wait_q != '0)
                      && (cnt_q[CNT_W-1 -: WAIT_W] == wait_q);
    end

    always_comb begin
        if (evt.restart || evt.match) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + CNT_ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wait_q  <= '0;
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            wait_q  <= wait_i;
            cnt_q   <= cnt_d;
            pulse_o <= evt.match;
        end
    end

    assign clr_o = evt.match;

    // R4: a match always sends the counter back to zero
    p_match_zero_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_o |=> (cnt_q == '0));

    // R4: quiet ticks advance the counter by exactly one
    p_tick_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !clr_o && (wait_i == wait_q)) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    // R6: a changed wait value restarts the count without a clear
    p_restart_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (wait_i != wait_q) |=> ((cnt_q == '0) && !pulse_o));

    // R4: the low counter bits are all zero when a match fires
    p_low_zero_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_o |-> (cnt_q[LOW_W-1:0] == '0));

endmodule

// File: rtl/pkh_extreme_reg.sv
module pkh_extreme_reg
    import pkh_pkg::*;
#(
    parameter int       SMP_W = SMP_W_DEF,
    parameter pkh_dir_e DIR   = TRK_MAX
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  pkh_upd_t                upd_i,
    input  logic signed [SMP_W-1:0] smp_i,
    output logic signed [SMP_W-1:0] q_o
);

    localparam logic signed [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic signed [SMP_W-1:0] MOST_POS = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic signed [SMP_W-1:0] IDLE_VAL = (DIR == TRK_MAX) ? MOST_NEG : MOST_POS;

    logic signed [SMP_W-1:0] base;
    logic                    wins;

    assign base = upd_i.clr ? IDLE_VAL : q_o;

    generate
        if (DIR == TRK_MAX) begin : g_max
            assign wins = (smp_i > base);
        end else begin : g_min
            assign wins = (smp_i < base);
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= IDLE_VAL;
        end else if (upd_i.vld && (upd_i.clr || wins)) begin
            q_o <= smp_i;
        end else begin
            q_o <= base;
        end
    end

    // R7: a sample coinciding with a clear seeds the register
    p_seed_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i.clr && upd_i.vld) |=> (q_o == $past(smp_i)));

    // R9: a clear without a sample restores the idle value
    p_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i.clr && !upd_i.vld) |=> (q_o == IDLE_VAL));

    // R3: no sample and no clear leaves the register alone
    p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!upd_i.clr && !upd_i.vld) |=> $stable(q_o));

    generate
        if (DIR == TRK_MAX) begin : g_max_chk
            // R2: between clears the maximum never falls
            p_max_mono_r2: assert property (@(posedge clk_i) disable iff (rst_i)
                !upd_i.clr |=> (q_o >= $past(q_o)));
        end else begin : g_min_chk
            // R2: between clears the minimum never rises
            p_min_mono_r2: assert property (@(posedge clk_i) disable iff (rst_i)
                !upd_i.clr |=> (q_o <= $past(q_o)));
        end
    endgenerate

endmodule

// File: rtl/peak_hold_timer.sv
module peak_hold_timer
    import pkh_pkg::*;
#(
    parameter int SMP_W  = SMP_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int WAIT_W = WAIT_W_DEF
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    tick_i,
    input  logic                    smp_vld_i,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic [WAIT_W-1:0]       wait_i,
    output logic signed [SMP_W-1:0] max_o,
    output logic signed [SMP_W-1:0] min_o,
    output logic                    clear_o
);

    logic     clr;
    pkh_upd_t upd;

    pkh_timeout #(
        .CNT_W  (CNT_W),
        .WAIT_W (WAIT_W)
    ) u_timeout (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick_i),
        .wait_i  (wait_i),
        .clr_o   (clr),
        .pulse_o (clear_o)
    );

    assign upd = pkh_make_upd(clr, smp_vld_i);

    pkh_extreme_reg #(
        .SMP_W (SMP_W),
        .DIR   (TRK_MAX)
    ) u_max (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .upd_i (upd),
        .smp_i (smp_i),
        .q_o   (max_o)
    );

    pkh_extreme_reg #(
        .SMP_W (SMP_W),
        .DIR   (TRK_MIN)
    ) u_min (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .upd_i (upd),
        .smp_i (smp_i),
        .q_o   (min_o)
    );

    // R8: the clear pulse never lasts two cycles
    p_pulse_once_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_o |=> !clear_o);

    // R5: a zero wait value never leads to a clear
    p_zero_off_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wait_i == '0) |=> !clear_o);

    // R2: a valid sample is bounded by both outputs afterwards
    p_bounds_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_vld_i |=> ((max_o >= $past(smp_i)) && (min_o <= $past(smp_i))));

endmodule

// File: tb/peak_hold_timer_bench.sv
module peak_hold_timer_bench;

    localparam int SW = 18;
    localparam int WW = 12;
    localparam logic signed [SW-1:0] NEG = 18'sh20000;
    localparam logic signed [SW-1:0] POS = 18'sh1FFFF;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 tick = 1'b0;
    logic                 vld = 1'b0;
    logic signed [SW-1:0] smp = '0;
    logic [WW-1:0]        wt = '0;
    logic signed [SW-1:0] max_o, min_o;
    logic                 clear_o;

    always #2.5 clk = ~clk;

    peak_hold_timer u_peak_hold_timer (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .smp_vld_i(vld), .smp_i(smp),
        .wait_i(wt), .max_o(max_o), .min_o(min_o), .clear_o(clear_o)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    chk_on = 1'b0;
    int    clr_seen = 0;
    int    run_hi = 0;
    int    run_max = 0;

    // Reference model written from the requirements
    logic signed [SW-1:0] m_max = NEG, m_min = POS;
    logic                 m_clr = 1'b0;
    logic [WW-1:0]        m_wait = '0;
    int unsigned          m_ticks = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_max <= NEG; m_min <= POS; m_clr <= 1'b0; m_wait <= '0; m_ticks <= 0;
        end else begin
            logic changed, fire;
            logic signed [SW-1:0] bmax, bmin;
            changed = (wt != m_wait);
            fire    = !changed && (m_wait != 0) && (m_ticks == 32'(m_wait) * 4096);
            bmax = fire ? NEG : m_max;
            bmin = fire ? POS : m_min;
            m_max <= (vld && (fire || smp > bmax)) ? smp : bmax;
            m_min <= (vld && (fire || smp < bmin)) ? smp : bmin;
            m_clr <= fire;
            m_wait <= wt;
            if (changed || fire) m_ticks <= 0;
            else if (tick) m_ticks <= (m_ticks + 1) & 32'hFFFFFF;
        end
    end

    task automatic check(input string t, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(tag, "max_o", max_o, m_max);
            check(tag, "min_o", min_o, m_min);
            check(tag, "clear_o", clear_o, m_clr);
            if (clear_o) begin
                clr_seen++;
                run_hi++;
                if (run_hi > run_max) run_max = run_hi;
            end else begin
                run_hi = 0;
            end
        end
    end

    function automatic logic signed [SW-1:0] rnd_smp();
        int unsigned r;
        r = $urandom;
        case (r % 8)
            0: return NEG;
            1: return POS;
            2: return -18'sd1;
            3: return SW'($signed(r % 64) - 32);
            default: return SW'(r >> 4);
        endcase
    endfunction

    task automatic run(input int n, input int vld_pct, input int tick_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld  = (($urandom % 100) < vld_pct);
            tick = (($urandom % 100) < tick_pct);
            smp  = rnd_smp();
        end
    endtask

    task automatic finish_run();
        chk_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        // R1: reset values while reset is held
        check("R1", "max_o in reset", max_o, NEG);
        check("R1", "min_o in reset", min_o, POS);
        check("R1", "clear_o in reset", clear_o, 0);
        rst = 1'b0;
        chk_on = 1'b1;
        @(negedge clk);
        check("R1", "max_o after reset", max_o, NEG);
        check("R1", "min_o after reset", min_o, POS);

        // R2: signed extremes, directed then random, timeout off
        tag = "R2";
        vld = 1'b1; smp = -18'sd1;
        @(negedge clk); smp = NEG;
        @(negedge clk); smp = POS;
        @(negedge clk); vld = 1'b0;
        check("R2", "max after POS", max_o, POS);
        check("R2", "min after NEG", min_o, NEG);
        run(1500, 40, 50);
        // R3: invalid samples must not move either output
        tag = "R3";
        run(500, 0, 50);

        // R4: wait 1 with continuous ticks
        tag = "R4";
        wt = 12'd1;
        clr_seen = 0;
        run(8300, 10, 100);
        check("R4", "clears in 8300 cycles at wait 1", clr_seen, 2);

        // R7: valid samples held through every clear
        tag = "R7";
        run(4200, 100, 100);

        // R9: no samples after the first few, so the clear restores idle values
        tag = "R9";
        wt = 12'd2;
        run(60, 100, 100);
        run(8300, 0, 100);
        check("R9", "max idle after clear", max_o, NEG);
        check("R9", "min idle after clear", min_o, POS);

        // R6: change the wait value mid-count
        tag = "R6";
        wt = 12'd2;
        run(100, 20, 100);
        wt = 12'd3;
        run(3000, 20, 100);
        clr_seen = 0;
        wt = 12'd1;
        run(4200, 20, 100);
        check("R6", "single clear after wait change", clr_seen, 1);

        // R5: zero wait, long run with ticks
        tag = "R5";
        wt = 12'd0;
        clr_seen = 0;
        run(9000, 20, 100);
        check("R5", "no clear with zero wait", clr_seen, 0);

        // R8: pulse width seen over the whole run
        check("R8", "longest clear_o run", run_max, 1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule